// File: doc/BRIEF.md
# Three-Operand Residue Adder with CRT Reconstruction

This block takes three operands that have already been encoded as residues over the pairwise-coprime moduli 5, 11 and 14. It adds the matching residues of the three operands inside each modulus channel, and no carry ever crosses from one channel to another. The three channel sums are then turned back into an ordinary binary number using the Chinese Remainder Theorem.

The dynamic range is 5·11·14 = 770. That is larger than 765, the largest sum of three 8-bit values, so any three operands in 0..255 are recovered exactly. A forward converter upstream supplies the nine residues. This block returns a registered 10-bit binary sum with a valid flag.

Top module: `rns_crt_sum`

## Requirements
- R1: Each operand port packs three 4-bit residue fields. Bits [3:0] hold the residue modulo 5, bits [7:4] the residue modulo 11, and bits [11:8] the residue modulo 14. Each channel adds its three fields modulo its own modulus, with no carry into any other channel.
- R2: Each channel sum is reduced into the range 0..m-1 by subtracting its modulus m zero, one or two times.
- R3: The binary result is the sum over the channels of weight·((residue·inverse) mod m), reduced modulo 770. The weights are 154, 70 and 55 and the inverses are 4, 3 and 13, in the order of moduli 5, 11 and 14. For operands in 0..255 the result equals the plain sum a+b+c.
- R4: A triple accepted with in_vld high at a rising edge yields sum_vld high for exactly one cycle, on the second rising edge after it. Results come out in the order the triples were accepted.
- R5: While sum_vld is low, sum_out holds its last value. A cycle with in_vld low produces no result.
- R6: A synchronous active-high rst clears sum_vld and sum_out to 0.
- R7: All-zero operands give 0, and three operands of 255 give 765, the top of the range.
- R8: A new triple may be accepted on every cycle, and consecutive triples give consecutive results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand triple is present this cycle |
| opa_res | input | 12 | Residues of operand A (fields as in R1) |
| opb_res | input | 12 | Residues of operand B |
| opc_res | input | 12 | Residues of operand C |
| sum_vld | output | 1 | sum_out carries a new result |
| sum_out | output | 10 | Binary sum, 0..769 |

## Verification
Each sum is due exactly two rising edges after the edge that accepted its triple. One register stage holds the channel sums and a second holds the reconstructed value. The driver stamps every expected sum with the cycle number at which it falls due. The monitor samples a quarter period after each rising edge and compares sum_vld and sum_out against the head of the queue only when that stamp matches. Any valid in a cycle with no stamp, and any change of sum_out while sum_vld is low, is reported against R4 and R5.

// File: rtl/rns_crt_pkg.sv
package rns_crt_pkg;

    localparam int NCH   = 3;
    localparam int SUM_W = 10;

    // moduli of the channels, pairwise coprime
    function automatic int modulus(input int k);
        case (k)
            0:       return 5;
            1:       return 11;
            default: return 14;
        endcase
    endfunction

    function automatic int dyn_range();
        int p;
        p = 1;
        for (int k = 0; k < NCH; k++) p = p * modulus(k);
        return p;
    endfunction

    function automatic int max_mod();
        int mx;
        mx = 0;
        for (int k = 0; k < NCH; k++) if (modulus(k) > mx) mx = modulus(k);
        return mx;
    endfunction

    // CRT position weight M/m
    function automatic int weight(input int k);
        return dyn_range() / modulus(k);
    endfunction

    // multiplicative inverse of the weight modulo its own modulus
    function automatic int inverse(input int k);
        int m;
        int w;
        m = modulus(k);
        w = weight(k) % m;
        for (int j = 1; j < m; j++) if (((w * j) % m) == 1) return j;
        return 0;
    endfunction

    // largest weighted sum before the final reduction
    function automatic int max_acc();
        int s;
        s = 0;
        for (int k = 0; k < NCH; k++) s = s + weight(k) * (modulus(k) - 1);
        return s;
    endfunction

    localparam int DYN   = dyn_range();
    localparam int RES_W = $clog2(max_mod());
    localparam int ACC_W = $clog2(max_acc() + 1);
    localparam int VEC_W = NCH * RES_W;

    typedef logic [RES_W-1:0]           res_t;
    typedef logic [NCH-1:0][RES_W-1:0]  res_vec_t;

    typedef struct packed {
        logic     vld;
        res_vec_t r;
    } chan_stage_t;

    typedef struct packed {
        logic             vld;
        logic [SUM_W-1:0] val;
    } out_stage_t;

endpackage

// File: rtl/rns_chan_add.sv
module rns_chan_add
    import rns_crt_pkg::*;
#(
    parameter int MODV = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  res_t a,
    input  res_t b,
    input  res_t c,
    output res_t r_q
);
    localparam int SW = RES_W + 2;
    localparam logic [SW-1:0] M1 = SW'(MODV);
    localparam logic [SW-1:0] M2 = SW'(2 * MODV);

    logic [SW-1:0] raw;
    logic [SW-1:0] red;

    assign raw = SW'(a) + SW'(b) + SW'(c);

    always_comb begin
        if (raw >= M2)      red = raw - M2;
        else if (raw >= M1) red = raw - M1;
        else                red = raw;
    end

    always_ff @(posedge clk) begin
        if (rst)     r_q <= '0;
        else if (en) r_q <= RES_W'(red);
    end

    // R2
    chan_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(r_q) < MODV));

endmodule

// File: rtl/crt_recon.sv
module crt_recon
    import rns_crt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_en,
    input  res_vec_t         res,
    output logic [SUM_W-1:0] bin
);
    localparam logic [ACC_W-1:0] D1 = ACC_W'(DYN);
    localparam logic [ACC_W-1:0] D2 = ACC_W'(2 * DYN);

    logic [NCH-1:0][ACC_W-1:0] term;
    logic [ACC_W-1:0]          acc;
    logic [ACC_W-1:0]          red;

    for (genvar k = 0; k < NCH; k++) begin : g_term
        localparam int MK = modulus(k);
        localparam int WK = weight(k);
        localparam int IK = inverse(k);
        int digit;
        always_comb begin
            digit   = (int'(res[k]) * IK) % MK;
            term[k] = ACC_W'(digit * WK);
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NCH; k++) acc = acc + term[k];
    end

    always_comb begin
        if (acc >= D2)      red = acc - D2;
        else if (acc >= D1) red = acc - D1;
        else                red = acc;
    end

    assign bin = SUM_W'(red);

    // R3
    crt_range_chk: assert property (@(posedge clk) disable iff (rst)
        chk_en |-> (int'(acc) <= max_acc()) && (int'(red) < DYN));

endmodule

// File: rtl/rns_crt_sum.sv
module rns_crt_sum
    import rns_crt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [VEC_W-1:0] opa_res,
    input  logic [VEC_W-1:0] opb_res,
    input  logic [VEC_W-1:0] opc_res,
    output logic             sum_vld,
    output logic [SUM_W-1:0] sum_out
);
    res_vec_t         va, vb, vc;
    chan_stage_t      s1;
    out_stage_t       s2;
    logic [SUM_W-1:0] bin;

    assign va = opa_res;
    assign vb = opb_res;
    assign vc = opc_res;

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        rns_chan_add #(.MODV(modulus(k))) u_add (
            .clk (clk),
            .rst (rst),
            .en  (in_vld),
            .a   (va[k]),
            .b   (vb[k]),
            .c   (vc[k]),
            .r_q (s1.r[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) s1.vld <= 1'b0;
        else     s1.vld <= in_vld;
    end

    crt_recon u_crt (
        .clk    (clk),
        .rst    (rst),
        .chk_en (s1.vld),
        .res    (s1.r),
        .bin    (bin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld <= s1.vld;
            if (s1.vld) s2.val <= bin;
        end
    end

    assign sum_vld = s2.vld;
    assign sum_out = s2.val;

    // R4
    lat_two_chk: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> $past(in_vld, 2));

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sum_vld |-> $stable(sum_out));

    // R6
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!sum_vld && sum_out == '0));

    // R3
    out_range_chk: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> (int'(sum_out) < DYN));

endmodule

// File: tb/rns_crt_sum_tb.sv
module rns_crt_sum_tb;
    import rns_crt_pkg::*;

    localparam int PERIOD = 10;
    localparam int WDOG   = 100000;

    typedef struct {
        int val;
        int due;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_vld = 1'b0;
    logic [VEC_W-1:0] opa_res = '0, opb_res = '0, opc_res = '0;
    logic             sum_vld;
    logic [SUM_W-1:0] sum_out;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   last_out = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rns_crt_sum u_dut (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .opa_res (opa_res),
        .opb_res (opb_res),
        .opc_res (opc_res),
        .sum_vld (sum_vld),
        .sum_out (sum_out)
    );

    // field layout of R1: [3:0] mod 5, [7:4] mod 11, [11:8] mod 14
    function automatic logic [VEC_W-1:0] enc(input int x);
        logic [VEC_W-1:0] v;
        v[3:0]  = 4'(x % 5);
        v[7:4]  = 4'(x % 11);
        v[11:8] = 4'(x % 14);
        return v;
    endfunction

    task automatic drive(input int a, input int b, input int c);
        exp_t e;
        @(negedge clk);
        in_vld  = 1'b1;
        opa_res = enc(a);
        opb_res = enc(b);
        opc_res = enc(c);
        e.val = a + b + c;
        e.due = cyc + 2;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld  = 1'b0;
            opa_res = enc((i * 37) % 256);
            opb_res = enc((i * 91) % 256);
            opc_res = enc((i * 13) % 256);
        end
    endtask

    // monitor
    always @(posedge clk) begin
        #(PERIOD/4);
        if (!rst && !done) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (!sum_vld) begin
                    errors++;
                    $display("FAIL R4 sum_vld act=%0b exp=1 cyc=%0d", sum_vld, cyc);
                end
                checks++;
                // R1 R2 R3 R7 R8: value equals plain binary sum
                if (int'(sum_out) != e.val) begin
                    errors++;
                    $display("FAIL R3 sum_out act=%0d exp=%0d", sum_out, e.val);
                end
                last_out = int'(sum_out);
            end else begin
                checks++;
                if (sum_vld) begin
                    errors++;
                    $display("FAIL R4 spurious sum_vld act=1 exp=0 cyc=%0d", cyc);
                end
                checks++;
                if (int'(sum_out) != last_out) begin
                    errors++;
                    $display("FAIL R5 sum_out moved while idle act=%0d exp=%0d",
                             sum_out, last_out);
                end
            end
        end
    end

    // watchdog
    initial begin
        for (int i = 0; i < WDOG; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%0d exp=<%0d cycles", WDOG, WDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R6 reset state
        checks++;
        if (sum_vld !== 1'b0 || sum_out !== '0) begin
            errors++;
            $display("FAIL R6 reset act=%0b/%0d exp=0/0", sum_vld, sum_out);
        end
        rst = 1'b0;
        idle(2);

        // R7 corners, back to back (R8)
        drive(0, 0, 0);
        drive(255, 255, 255);
        drive(255, 0, 0);
        drive(0, 0, 255);
        drive(254, 255, 255);
        drive(1, 1, 1);
        idle(4);

        // R5: no result from idle cycles with changing operands
        drive(100, 200, 150);
        idle(5);

        // R1 R3: channel wrap patterns (multiples of each modulus, near wraps)
        drive(4, 4, 4);
        drive(10, 10, 10);
        drive(13, 13, 13);
        drive(154, 70, 55);
        drive(169, 169, 169);
        idle(3);

        // random triples with random gaps (R8 back to back when no gap)
        for (int i = 0; i < 400; i++) begin
            drive(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)));
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(6);

        done = 1'b1;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R4 results missing act=%0d exp=0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule